// File: doc/BRIEF.md
# Microcoded Accumulator Datapath

This block is the register-transfer half of a small accumulator processor. It holds a 16-bit accumulator, a 16-bit data register, an 11-bit address register, an 11-bit program counter and a 2048-word memory of 16-bit words. An external control sequencer drives three 3-bit micro-operation fields every cycle. Each field has its own one-hot decoder. The block performs every selected transfer, arithmetic, logic or shift step on the next rising clock edge.

All transfers in a cycle read the register values from before the edge. Two fields can therefore swap the accumulator and the data register in one cycle, or a memory read can run alongside a program-counter increment. The block drives status bits back to the sequencer: the top data-register bit (indirect flag), the accumulator sign and an accumulator-zero flag. It also drives the four opcode bits held in the data register. A side port lets a testbench preload and inspect memory.

Top module: `acc_datapath`

## Requirements
- R1: While `rst` is high at a rising edge, the accumulator, data, address and program-counter registers all become 0.
- R2: Code 0 in every field, and code 7 in the third field, changes no register and no memory word.
- R3: First-field codes 1, 2, 3 and 4 load the accumulator with, in turn: accumulator plus data modulo 2^16; zero; accumulator plus one modulo 2^16; the data register.
- R4: First-field code 5 loads the address register with data bits [10:0]. First-field code 6 copies the program counter into the address register.
- R5: First-field code 7 writes the data register into the memory word at the address register on the clock edge.
- R6: Second-field codes 1, 2 and 3 load the accumulator with, in turn: accumulator minus data modulo 2^16; bitwise OR; bitwise AND.
- R7: Second-field code 4 loads the data register from the memory word at the address register, read in the same cycle. Code 5 copies the accumulator into the data register. Code 6 increments the data register modulo 2^16. Code 7 replaces data bits [10:0] with the program counter and keeps bits [15:11].
- R8: Third-field codes 1, 2, 3 and 4 load the accumulator with, in turn: bitwise XOR with data; its complement; a left shift; a right shift. Both shifts fill with 0 and drop the bit shifted out.
- R9: Third-field code 5 increments the program counter modulo 2^11. Third-field code 6 loads the program counter from the address register.
- R10: Operations from different fields in one cycle all read the pre-edge register values. First code 4 with second code 5 swaps the accumulator and the data register.
- R11: When more than one active field writes the accumulator, the first field wins over the second, and the second wins over the third.
- R12: Status outputs follow the current registers with no delay: `ind_o` is data bit 15, `sign_o` is accumulator bit 15, `zero_o` is 1 when the accumulator is 0, and `opcode_o` is data bits [14:11].
- R13: With `tb_we` high, the word `tb_wdata` is written at `tb_addr` on the clock edge. `tb_rdata` shows the word at `tb_addr` with no delay.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| f1 | input | 3 | First micro-operation field |
| f2 | input | 3 | Second micro-operation field |
| f3 | input | 3 | Third micro-operation field |
| ind_o | output | 1 | Data register bit 15 |
| sign_o | output | 1 | Accumulator bit 15 |
| zero_o | output | 1 | Accumulator equals zero |
| opcode_o | output | 4 | Data register bits [14:11] |
| ac_o | output | 16 | Accumulator value |
| dr_o | output | 16 | Data register value |
| ar_o | output | 11 | Address register value |
| pc_o | output | 11 | Program counter value |
| tb_we | input | 1 | Side-port memory write enable |
| tb_addr | input | 11 | Side-port memory address |
| tb_wdata | input | 16 | Side-port memory write word |
| tb_rdata | output | 16 | Side-port memory read word |

## Verification
The assertions assume the side-port write enable is never high in a cycle where the first field requests a memory write. The bench keeps the side-port write enable low whenever it drives a non-zero field. The assertions also assume the fields are held steady across each clock edge. The bench changes fields only on falling edges and returns them to zero after every step. Colliding writes to one register are made only in the scenario that checks field priority.

// File: rtl/dp_pkg.sv
package dp_pkg;
    parameter int DATA_W  = 16;
    parameter int ADDR_W  = 11;
    parameter int FIELD_W = 3;
    localparam int CODES  = 1 << FIELD_W;
    localparam int OP_W   = DATA_W - 1 - ADDR_W;
    localparam int DEPTH  = 1 << ADDR_W;

    typedef struct packed {
        logic [DATA_W-1:0] ac;
        logic [DATA_W-1:0] dr;
        logic [ADDR_W-1:0] ar;
        logic [ADDR_W-1:0] pc;
    } dp_regs_t;

    typedef enum logic [FIELD_W-1:0] {
        A_NOP = 3'd0, A_ADD = 3'd1, A_CLR = 3'd2, A_INC = 3'd3,
        A_LDD = 3'd4, A_ARD = 3'd5, A_ARP = 3'd6, A_WR  = 3'd7
    } f1_code_e;

    typedef enum logic [FIELD_W-1:0] {
        B_NOP = 3'd0, B_SUB = 3'd1, B_OR  = 3'd2, B_AND = 3'd3,
        B_RD  = 3'd4, B_DRA = 3'd5, B_INC = 3'd6, B_DRP = 3'd7
    } f2_code_e;

    typedef enum logic [FIELD_W-1:0] {
        C_NOP = 3'd0, C_XOR = 3'd1, C_COM = 3'd2, C_SHL = 3'd3,
        C_SHR = 3'd4, C_PCI = 3'd5, C_PCA = 3'd6, C_RSV = 3'd7
    } f3_code_e;
endpackage

// File: rtl/dp_field_dec.sv
module dp_field_dec
    import dp_pkg::*;
(
    input  logic [FIELD_W-1:0] code,
    output logic [CODES-1:0]   hot
);
    for (genvar i = 0; i < CODES; i++) begin : g_bit
        assign hot[i] = (code == FIELD_W'(i));
    end
endmodule

// File: rtl/dp_ram.sv
module dp_ram
    import dp_pkg::*;
(
    input  logic              clk,
    input  logic              dp_we,
    input  logic [ADDR_W-1:0] dp_addr,
    input  logic [DATA_W-1:0] dp_wdata,
    output logic [DATA_W-1:0] dp_rdata,
    input  logic              tb_we,
    input  logic [ADDR_W-1:0] tb_addr,
    input  logic [DATA_W-1:0] tb_wdata,
    output logic [DATA_W-1:0] tb_rdata
);
    logic [DATA_W-1:0] mem_q [DEPTH];

    always_ff @(posedge clk) begin
        if (tb_we) begin
            mem_q[tb_addr] <= tb_wdata;
        end else if (dp_we) begin
            mem_q[dp_addr] <= dp_wdata;
        end
    end

    assign dp_rdata = mem_q[dp_addr];
    assign tb_rdata = mem_q[tb_addr];
endmodule

// File: rtl/dp_next.sv
module dp_next
    import dp_pkg::*;
(
    input  dp_regs_t          regs_q,
    input  logic [CODES-1:0]  h1,
    input  logic [CODES-1:0]  h2,
    input  logic [CODES-1:0]  h3,
    input  logic [DATA_W-1:0] mem_rdata,
    output dp_regs_t          regs_d,
    output logic              mem_we_d
);
    // Fields are applied lowest priority first so later writes win.
    always_comb begin
        regs_d   = regs_q;
        mem_we_d = 1'b0;

        // third field
        if (h3[C_XOR]) regs_d.ac = regs_q.ac ^ regs_q.dr;
        if (h3[C_COM]) regs_d.ac = ~regs_q.ac;
        if (h3[C_SHL]) regs_d.ac = {regs_q.ac[DATA_W-2:0], 1'b0};
        if (h3[C_SHR]) regs_d.ac = {1'b0, regs_q.ac[DATA_W-1:1]};
        if (h3[C_PCI]) regs_d.pc = regs_q.pc + 1'b1;
        if (h3[C_PCA]) regs_d.pc = regs_q.ar;

        // second field
        if (h2[B_SUB]) regs_d.ac = regs_q.ac - regs_q.dr;
        if (h2[B_OR])  regs_d.ac = regs_q.ac | regs_q.dr;
        if (h2[B_AND]) regs_d.ac = regs_q.ac & regs_q.dr;
        if (h2[B_RD])  regs_d.dr = mem_rdata;
        if (h2[B_DRA]) regs_d.dr = regs_q.ac;
        if (h2[B_INC]) regs_d.dr = regs_q.dr + 1'b1;
        if (h2[B_DRP]) regs_d.dr = {regs_q.dr[DATA_W-1:ADDR_W], regs_q.pc};

        // first field
        if (h1[A_ADD]) regs_d.ac = regs_q.ac + regs_q.dr;
        if (h1[A_CLR]) regs_d.ac = '0;
        if (h1[A_INC]) regs_d.ac = regs_q.ac + 1'b1;
        if (h1[A_LDD]) regs_d.ac = regs_q.dr;
        if (h1[A_ARD]) regs_d.ar = regs_q.dr[ADDR_W-1:0];
        if (h1[A_ARP]) regs_d.ar = regs_q.pc;
        if (h1[A_WR])  mem_we_d  = 1'b1;
    end
endmodule

// File: rtl/acc_datapath.sv
module acc_datapath
    import dp_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic [FIELD_W-1:0] f1,
    input  logic [FIELD_W-1:0] f2,
    input  logic [FIELD_W-1:0] f3,
    output logic               ind_o,
    output logic               sign_o,
    output logic               zero_o,
    output logic [OP_W-1:0]    opcode_o,
    output logic [DATA_W-1:0]  ac_o,
    output logic [DATA_W-1:0]  dr_o,
    output logic [ADDR_W-1:0]  ar_o,
    output logic [ADDR_W-1:0]  pc_o,
    input  logic               tb_we,
    input  logic [ADDR_W-1:0]  tb_addr,
    input  logic [DATA_W-1:0]  tb_wdata,
    output logic [DATA_W-1:0]  tb_rdata
);
    localparam int NF = 3;

    logic [FIELD_W-1:0] codes [NF];
    logic [CODES-1:0]   hots  [NF];
    dp_regs_t           regs_q, regs_d;
    logic               mem_we_d;
    logic [DATA_W-1:0]  mem_rdata;

    assign codes[0] = f1;
    assign codes[1] = f2;
    assign codes[2] = f3;

    for (genvar g = 0; g < NF; g++) begin : g_dec
        dp_field_dec u_dec (
            .code (codes[g]),
            .hot  (hots[g])
        );
    end

    dp_next u_next (
        .regs_q    (regs_q),
        .h1        (hots[0]),
        .h2        (hots[1]),
        .h3        (hots[2]),
        .mem_rdata (mem_rdata),
        .regs_d    (regs_d),
        .mem_we_d  (mem_we_d)
    );

    dp_ram u_ram (
        .clk      (clk),
        .dp_we    (mem_we_d),
        .dp_addr  (regs_q.ar),
        .dp_wdata (regs_q.dr),
        .dp_rdata (mem_rdata),
        .tb_we    (tb_we),
        .tb_addr  (tb_addr),
        .tb_wdata (tb_wdata),
        .tb_rdata (tb_rdata)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            regs_q <= '0;
        end else begin
            regs_q <= regs_d;
        end
    end

    assign ac_o     = regs_q.ac;
    assign dr_o     = regs_q.dr;
    assign ar_o     = regs_q.ar;
    assign pc_o     = regs_q.pc;
    assign ind_o    = regs_q.dr[DATA_W-1];
    assign sign_o   = regs_q.ac[DATA_W-1];
    assign zero_o   = (regs_q.ac == '0);
    assign opcode_o = regs_q.dr[DATA_W-2:ADDR_W];

    // R1
    reset_clear_chk: assert property (@(posedge clk)
        rst |=> (ac_o == '0 && dr_o == '0 && ar_o == '0 && pc_o == '0));

    // R2
    idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (f1 == '0 && f2 == '0 && (f3 == '0 || f3 == C_RSV)) |=> $stable(regs_q));

    // R3
    clear_ac_chk: assert property (@(posedge clk) disable iff (rst)
        (f1 == A_CLR) |=> (ac_o == '0));

    // R4
    ar_from_pc_chk: assert property (@(posedge clk) disable iff (rst)
        (f1 == A_ARP) |=> (ar_o == $past(pc_o)));

    // R7
    dr_read_chk: assert property (@(posedge clk) disable iff (rst)
        (f2 == B_RD) |=> (dr_o == $past(mem_rdata)));

    // R9
    pc_inc_chk: assert property (@(posedge clk) disable iff (rst)
        (f3 == C_PCI) |=> (pc_o == ADDR_W'($past(pc_o) + 1'b1)));

    // R5
    mem_write_chk: assert property (@(posedge clk) disable iff (rst)
        (f1 == A_WR && !tb_we && f2 == '0 && f3 == '0) |=> (mem_rdata == $past(dr_o)));
endmodule

// File: tb/acc_datapath_bench.sv
module acc_datapath_bench;
    logic        clk = 1'b0;
    logic        rst;
    logic [2:0]  f1, f2, f3;
    logic        ind_o, sign_o, zero_o;
    logic [3:0]  opcode_o;
    logic [15:0] ac_o, dr_o;
    logic [10:0] ar_o, pc_o;
    logic        tb_we;
    logic [10:0] tb_addr;
    logic [15:0] tb_wdata, tb_rdata;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #2 clk = ~clk;

    acc_datapath u_acc_datapath (
        .clk(clk), .rst(rst), .f1(f1), .f2(f2), .f3(f3),
        .ind_o(ind_o), .sign_o(sign_o), .zero_o(zero_o), .opcode_o(opcode_o),
        .ac_o(ac_o), .dr_o(dr_o), .ar_o(ar_o), .pc_o(pc_o),
        .tb_we(tb_we), .tb_addr(tb_addr), .tb_wdata(tb_wdata), .tb_rdata(tb_rdata)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic step(input logic [2:0] a, input logic [2:0] b, input logic [2:0] c);
        @(negedge clk);
        f1 = a; f2 = b; f3 = c;
        @(negedge clk);
        f1 = 0; f2 = 0; f3 = 0;
    endtask

    task automatic poke(input logic [10:0] a, input logic [15:0] d);
        @(negedge clk);
        tb_we = 1; tb_addr = a; tb_wdata = d;
        @(negedge clk);
        tb_we = 0;
    endtask

    task automatic peek(input logic [10:0] a, output logic [15:0] d);
        tb_addr = a;
        #1;
        d = tb_rdata;
    endtask

    task automatic set_dr(input logic [15:0] v);
        poke(ar_o, v);
        step(0, 4, 0);
    endtask

    task automatic set_ac(input logic [15:0] v);
        set_dr(v);
        step(4, 0, 0);
    endtask

    task automatic set_ar(input logic [10:0] a);
        set_dr({5'd0, a});
        step(5, 0, 0);
    endtask

    task automatic set_pc(input logic [10:0] a);
        set_ar(a);
        step(0, 0, 6);
    endtask

    task automatic t_reset;
        rst = 1;
        repeat (2) @(negedge clk);
        rst = 0;
        check("R1 ac", ac_o, 0);
        check("R1 dr", dr_o, 0);
        check("R1 ar", ar_o, 0);
        check("R1 pc", pc_o, 0);
        check("R12 zero after reset", zero_o, 1);
    endtask

    task automatic t_side_port;
        logic [15:0] d;
        poke(11'h7FF, 16'hA5C3);
        peek(11'h7FF, d);
        check("R13 preload readback", d, 16'hA5C3);
    endtask

    task automatic t_idle;
        logic [15:0] d;
        set_pc(11'h055);
        set_ac(16'h3C3C);
        set_ar(11'h0F0);
        poke(11'h0F0, 16'h1357);
        step(0, 0, 0);
        step(0, 0, 7);
        check("R2 ac", ac_o, 16'h3C3C);
        check("R2 dr", dr_o, 16'h00F0);
        check("R2 ar", ar_o, 11'h0F0);
        check("R2 pc", pc_o, 11'h055);
        peek(11'h0F0, d);
        check("R2 mem", d, 16'h1357);
    endtask

    task automatic t_f1_ac;
        set_ac(16'hFFFF);
        set_dr(16'h0002);
        step(1, 0, 0);
        check("R3 add wrap", ac_o, 16'h0001);
        step(2, 0, 0);
        check("R3 clear", ac_o, 0);
        set_ac(16'hFFFF);
        step(3, 0, 0);
        check("R3 inc wrap", ac_o, 0);
        set_dr(16'h4321);
        step(4, 0, 0);
        check("R3 load dr", ac_o, 16'h4321);
    endtask

    task automatic t_f1_ar;
        set_dr(16'hF8A5);
        step(5, 0, 0);
        check("R4 ar from dr", ar_o, 11'h0A5);
        set_pc(11'h321);
        step(6, 0, 0);
        check("R4 ar from pc", ar_o, 11'h321);
    endtask

    task automatic t_write;
        logic [15:0] d;
        set_ar(11'h123);
        poke(11'h123, 16'hBEEF);
        step(0, 4, 0);
        poke(11'h123, 16'h0000);
        step(7, 0, 0);
        peek(11'h123, d);
        check("R5 memory write", d, 16'hBEEF);
    endtask

    task automatic t_f2_ac;
        logic [15:0] a, b;
        a = 16'h1234; b = 16'h0235;
        set_ac(a); set_dr(b);
        step(0, 1, 0);
        check("R6 sub", ac_o, 16'h0FFF);
        set_ac(16'h0001); set_dr(16'h0002);
        step(0, 1, 0);
        check("R6 sub wrap", ac_o, 16'hFFFF);
        set_ac(a); set_dr(b);
        step(0, 2, 0);
        check("R6 or", ac_o, a | b);
        set_ac(a); set_dr(b);
        step(0, 3, 0);
        check("R6 and", ac_o, a & b);
    endtask

    task automatic t_f2_dr;
        set_ar(11'h200);
        poke(11'h200, 16'h9ABC);
        step(0, 4, 0);
        check("R7 read", dr_o, 16'h9ABC);
        set_ac(16'h7777);
        step(0, 5, 0);
        check("R7 dr from ac", dr_o, 16'h7777);
        set_dr(16'hFFFF);
        step(0, 6, 0);
        check("R7 inc wrap", dr_o, 0);
        set_pc(11'h155);
        set_dr(16'hF800);
        step(0, 7, 0);
        check("R7 low bits from pc", dr_o, 16'hF955);
    endtask

    task automatic t_f3_ac;
        set_ac(16'h0F0F); set_dr(16'h00FF);
        step(0, 0, 1);
        check("R8 xor", ac_o, 16'h0FF0);
        step(0, 0, 2);
        check("R8 complement", ac_o, 16'hF00F);
        set_ac(16'h8001);
        step(0, 0, 3);
        check("R8 shl", ac_o, 16'h0002);
        set_ac(16'h8001);
        step(0, 0, 4);
        check("R8 shr", ac_o, 16'h4000);
    endtask

    task automatic t_f3_pc;
        set_pc(11'h7FF);
        step(0, 0, 5);
        check("R9 inc wrap", pc_o, 0);
        set_ar(11'h2AA);
        step(0, 0, 6);
        check("R9 pc from ar", pc_o, 11'h2AA);
    endtask

    task automatic t_concurrent;
        set_ac(16'h1111); set_dr(16'h2222);
        step(4, 5, 0);
        check("R10 swap ac", ac_o, 16'h2222);
        check("R10 swap dr", dr_o, 16'h1111);
        set_pc(11'h040);
        set_ar(11'h300);
        poke(11'h300, 16'h5A5A);
        step(6, 4, 5);
        check("R10 read dr", dr_o, 16'h5A5A);
        check("R10 ar old pc", ar_o, 11'h040);
        check("R10 pc inc", pc_o, 11'h041);
    endtask

    task automatic t_priority;
        set_ac(16'h00F0); set_dr(16'h0F00);
        step(2, 2, 2);
        check("R11 first field wins", ac_o, 0);
        set_ac(16'h00F0); set_dr(16'h0FF0);
        step(0, 3, 2);
        check("R11 second over third", ac_o, 16'h00F0);
    endtask

    task automatic t_status;
        set_dr(16'hC800);
        check("R12 ind", ind_o, 1);
        check("R12 opcode", opcode_o, 4'h9);
        set_ac(16'h8000);
        check("R12 sign", sign_o, 1);
        check("R12 zero low", zero_o, 0);
    endtask

    initial begin
        #(4 * 200000);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        rst = 1; f1 = 0; f2 = 0; f3 = 0;
        tb_we = 0; tb_addr = 0; tb_wdata = 0;
        t_reset();
        t_side_port();
        t_idle();
        t_f1_ac();
        t_f1_ar();
        t_write();
        t_f2_ac();
        t_f2_dr();
        t_f3_ac();
        t_f3_pc();
        t_concurrent();
        t_priority();
        t_status();
        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule